// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two free-running interval timers for an audio and I/O peripheral. Each timer is set by two 16-bit values, a prescale count and a divide count. A running timer raises a one-clock interrupt request every (prescale+1)*(divide+1) system clocks. After each request it reloads itself, so it keeps firing at that rate. If either of a timer's two values is zero, that timer is stopped.

The four values sit on a small register bus and can be read back. Writes may be a full 16-bit word or a single byte, and so may reads. Any write to a timer's values restarts that timer on the same clock edge, from the start of a full period. The two interrupt requests go to an external interrupt controller, which handles enabling, latching and priority.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset all four timer registers read 0xFFFF and both interrupt request outputs are low.
- R2: Word access uses `bus_addr[2:1]` to pick the register: 0 is the timer 1 prescale value, 1 is the timer 1 divide value, 2 is the timer 2 prescale value, 3 is the timer 2 divide value. A word write stores all 16 bits of `bus_wdata`, and a word read returns the 16-bit register.
- R3: A byte write with `bus_addr[0]`=0 replaces bits 15:8 of the register with `bus_wdata[7:0]`. A byte write with `bus_addr[0]`=1 replaces bits 7:0. In both cases the other byte and `bus_wdata[15:8]` are left unused. A byte read returns the same byte in bits 7:0, with bits 15:8 zero.
- R4: While a timer runs, its request output is high for exactly one clock, once every (P+1)*(D+1) clocks. P is that timer's prescale value and D is its divide value.
- R5: Any write to a timer's register restarts that timer from the written clock edge. The first request is exactly (P+1)*(D+1) clocks later, and any partly elapsed period is dropped.
- R6: A timer whose prescale value or divide value is zero gives no requests.
- R7: A write to one timer's registers does not change the phase of the other timer.
- R8: After reset both timers stay idle, with no requests, until one of their registers is written, even though the registers hold nonzero values.
- R9: A byte write restarts its timer just as a word write does, using the merged 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; timers count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 3 | Byte address of the access |
| bus_wdata | input | 16 | Write data; only bits 7:0 are used for byte writes |
| bus_rdata | output | 16 | Readback of the addressed register or byte |
| tick_irq | output | 2 | One-clock interrupt requests; bit 0 is timer 1, bit 1 is timer 2 |

## Verification
The hardest case to reach from the ports is a restart that lands partway through a period. The new period has to count from the write edge and not from the previous request. The stimulus syncs to a request, waits two clocks, and rewrites only the divide value. It then checks that the next request comes after exactly the new period. A second sequence syncs to timer 1 and rewrites timer 2 between two timer 1 requests. It checks that timer 1's interval is unchanged, which shows that restarts stay within their own timer.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned TMR_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_TMR = 2;
  localparam int unsigned ADDR_W  = 3;

  typedef struct packed {
    logic [TMR_W-1:0] pre;
    logic [TMR_W-1:0] div;
  } tmr_cfg_t;
endpackage

// File: rtl/dit_rst_sync.sv
module dit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic                               bus_word,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [TMR_W-1:0]                   bus_wdata,
  output logic [TMR_W-1:0]                   bus_rdata,
  output tmr_cfg_t [NUM_TMR-1:0]             cfg_q,
  output tmr_cfg_t [NUM_TMR-1:0]             cfg_nxt,
  output logic [NUM_TMR-1:0]                 load
);
  localparam int unsigned HI_LSB = TMR_W - BYTE_W;

  logic             tsel;
  logic             fsel;
  logic [TMR_W-1:0] cur_val;
  logic [TMR_W-1:0] new_val;

  assign tsel = bus_addr[2];
  assign fsel = bus_addr[1];

  always_comb begin
    cur_val = fsel ? cfg_q[tsel].div : cfg_q[tsel].pre;
    if (bus_word)         new_val = bus_wdata;
    else if (bus_addr[0]) new_val = {cur_val[TMR_W-1:BYTE_W], bus_wdata[BYTE_W-1:0]};
    else                  new_val = {bus_wdata[BYTE_W-1:0], cur_val[HI_LSB-1:0]};
  end

  always_comb begin
    cfg_nxt = cfg_q;
    load    = '0;
    if (bus_wr) begin
      if (fsel) cfg_nxt[tsel].div = new_val;
      else      cfg_nxt[tsel].pre = new_val;
      load[tsel] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        cfg_q[i].pre <= '1;
        cfg_q[i].div <= '1;
      end
    end else if (bus_wr) begin
      cfg_q <= cfg_nxt;
    end
  end

  always_comb begin
    if (bus_word)         bus_rdata = cur_val;
    else if (bus_addr[0]) bus_rdata = {{HI_LSB{1'b0}}, cur_val[BYTE_W-1:0]};
    else                  bus_rdata = {{HI_LSB{1'b0}}, cur_val[TMR_W-1:HI_LSB]};
  end

  // R2: register contents move only on a bus write
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(cfg_q));
endmodule

// File: rtl/dit_chan.sv
module dit_chan
  import dit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tmr_cfg_t cfg_nxt,
  input  tmr_cfg_t cfg_q,
  output logic     irq
);
  logic             run_q,  run_d;
  logic [TMR_W-1:0] pcnt_q, pcnt_d;
  logic [TMR_W-1:0] dcnt_q, dcnt_d;
  logic             irq_q,  irq_d;
  logic             cnt_en;

  assign cnt_en = load | run_q;

  always_comb begin
    run_d  = run_q;
    pcnt_d = pcnt_q;
    dcnt_d = dcnt_q;
    irq_d  = 1'b0;
    if (load) begin
      run_d  = (cfg_nxt.pre != '0) && (cfg_nxt.div != '0);
      pcnt_d = cfg_nxt.pre;
      dcnt_d = cfg_nxt.div;
    end else if (run_q) begin
      if (pcnt_q == '0) begin
        pcnt_d = cfg_q.pre;
        if (dcnt_q == '0) begin
          dcnt_d = cfg_q.div;
          irq_d  = 1'b1;
        end else begin
          dcnt_d = dcnt_q - 1'b1;
        end
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (cnt_en) begin
      run_q  <= run_d;
      pcnt_q <= pcnt_d;
      dcnt_q <= dcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R4: a request never lasts longer than one clock
  p_irq_one_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R6 / R8: an idle timer gives no request
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !irq_q);
  // R5: the running count stays within the stored period values
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pcnt_q <= cfg_q.pre) && (dcnt_q <= cfg_q.div));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TMR_W-1:0]  bus_wdata,
  output logic [TMR_W-1:0]  bus_rdata,
  output logic [NUM_TMR-1:0] tick_irq
);
  logic                      rst_n_sync;
  tmr_cfg_t [NUM_TMR-1:0]    cfg_q;
  tmr_cfg_t [NUM_TMR-1:0]    cfg_nxt;
  logic [NUM_TMR-1:0]        load;

  dit_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  dit_regs regs_i (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cfg_q    (cfg_q),
    .cfg_nxt  (cfg_nxt),
    .load     (load)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
    dit_chan chan_i (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .load   (load[g]),
      .cfg_nxt(cfg_nxt[g]),
      .cfg_q  (cfg_q[g]),
      .irq    (tick_irq[g])
    );
  end

  // R7: a write strobes the restart of exactly one timer
  p_one_load_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0(load));
endmodule

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_word;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  tick_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  // {prescale, divide, expected period or 0 for stopped}
  localparam logic [47:0] VEC [7] = '{
    {16'd1, 16'd1, 16'd4},
    {16'd2, 16'd1, 16'd6},
    {16'd1, 16'd3, 16'd8},
    {16'd4, 16'd2, 16'd15},
    {16'd0, 16'd5, 16'd0},
    {16'd3, 16'd0, 16'd0},
    {16'd9, 16'd9, 16'd100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic w, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_word = w;
    #1 v = bus_rdata;
  endtask

  task automatic wait_irq(input int b, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_irq[b] && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, m, seen;
    bus_wr = 0; bus_word = 1; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset contents
    for (int i = 0; i < 4; i++) begin
      rd(3'(i * 2), 1'b1, v);
      check(v == 16'hFFFF, "R1 reset value", v, 16'hFFFF);
    end
    // R8: idle until written
    seen = 0;
    repeat (200) begin @(negedge clk); if (tick_irq != 0) seen++; end
    check(seen == 0, "R8 idle after reset", seen, 0);

    // R2/R4/R5/R6: table walk on timer 1
    for (int k = 0; k < 7; k++) begin
      wr(3'd0, 1'b1, VEC[k][47:32]);
      wr(3'd2, 1'b1, VEC[k][31:16]);
      if (VEC[k][15:0] != 0) begin
        wait_irq(0, n);
        check(n == int'(VEC[k][15:0]), "R5 first period", n, VEC[k][15:0]);
        @(negedge clk);
        check(tick_irq[0] == 1'b0, "R4 one clock wide", tick_irq[0], 0);
        wait_irq(0, m);
        check(m + 1 == int'(VEC[k][15:0]), "R4 repeat period", m + 1, VEC[k][15:0]);
      end else begin
        seen = 0;
        repeat (60) begin @(negedge clk); if (tick_irq[0]) seen++; end
        check(seen == 0, "R6 zero stops timer", seen, 0);
      end
      rd(3'd2, 1'b1, v);
      check(v == VEC[k][31:16], "R2 divide readback", v, VEC[k][31:16]);
    end

    // R5: restart in mid period
    wr(3'd0, 1'b1, 16'd1);
    wr(3'd2, 1'b1, 16'd1);
    wait_irq(0, n);
    repeat (2) @(negedge clk);
    wr(3'd2, 1'b1, 16'd2);
    wait_irq(0, n);
    check(n == 6, "R5 mid period restart", n, 6);

    // R9: byte write to low byte of prescale restarts
    wr(3'd1, 1'b0, 16'hEE03);
    wait_irq(0, n);
    check(n == 12, "R9 byte write restart", n, 12);
    rd(3'd0, 1'b1, v);
    check(v == 16'd3, "R9 merged value", v, 3);

    // timer 2 period
    wr(3'd4, 1'b1, 16'd2);
    wr(3'd6, 1'b1, 16'd1);
    wait_irq(1, n);
    check(n == 6, "R2 timer 2 period", n, 6);

    // R7: timer 2 write leaves timer 1 phase intact
    wait_irq(0, n);
    wr(3'd4, 1'b1, 16'd2);
    wait_irq(0, m);
    check(m + 2 == 12, "R7 independent phase", m + 2, 12);

    // R3: byte writes and byte reads
    wr(3'd6, 1'b1, 16'h00AB);
    wr(3'd6, 1'b0, 16'h7712);
    rd(3'd6, 1'b1, v);
    check(v == 16'h12AB, "R3 high byte write", v, 16'h12AB);
    rd(3'd7, 1'b0, v);
    check(v == 16'h00AB, "R3 low byte read", v, 16'h00AB);
    rd(3'd6, 1'b0, v);
    check(v == 16'h0012, "R3 high byte read", v, 16'h0012);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule